// File: doc/BRIEF.md
# Byte-Wide Indirect Memory Access Port

This block lets a host processor with an 8-bit data bus reach a 32 KB internal memory of a network controller through a window of only four byte registers. The host loads a 15-bit pointer through two address registers, then moves bytes through a data register. Each data access can step the pointer on by one, so a whole buffer streams through one I/O location.

A mode register holds two option bits and a self-clearing reset request. The block decodes the host cycle, keeps the mode bits and the pointer, and drives a simple synchronous memory port. Read data is presented one clock after the host read, with a valid strobe. A mode write that sets any unsupported bit is refused, and an error pulse is raised.

Top module: `ibus_host_port`

## Requirements
- R1: Only host cycles whose address has bit 2 set (offsets 4 to 7) are decoded. Any other host cycle leaves the memory strobes low, raises no read-valid and changes no state.
- R2: Writing the mode register (offset 4) with a legal value stores bit 1 (auto-increment) and bit 0 (indirect mode). A mode read returns {6'b0, bit1, bit0} one cycle later with `hostRvalid` high.
- R3: A mode write with any of bits 6..2 set is illegal. It changes neither the mode nor the pointer, and `modeErr` is high for exactly the following cycle.
- R4: A legal mode write with bit 7 set clears the pointer and both mode bits. Bit 7 is never stored, so the mode register then reads 0x00.
- R5: A write to offset 5 loads pointer bits 14:8 from data bits 6:0. Pointer bits 7:0 are kept.
- R6: A write to offset 6 loads pointer bits 7:0 from the data. Pointer bits 14:8 are kept.
- R7: A write to offset 7 stores the byte at the pointer. A read of offset 7 returns the byte at the pointer one cycle later, with `hostRvalid` high.
- R8: When auto-increment is on, every data access advances the pointer by one. The pointer wraps from 0x7FFF to 0x0000.
- R9: When auto-increment is off, data accesses leave the pointer unchanged.
- R10: Reads of offsets 5 and 6 return 0x00 with `hostRvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host cycle strobe, one clock per access |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Host I/O offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data, valid while hostRvalid is high |
| hostRvalid | output | 1 | Read response, one cycle after a decoded read |
| modeErr | output | 1 | One-cycle pulse after an illegal mode write |
| memAddr | output | 15 | Internal memory address (current pointer) |
| memWe | output | 1 | Internal memory write strobe |
| memRe | output | 1 | Internal memory read strobe |
| memWdata | output | 8 | Internal memory write data |
| memRdata | input | 8 | Internal memory read data, one cycle after memRe |

## Verification
Two activities can fall in the same cycle: a read response, and the pointer update of the next host access. Back-to-back data reads with auto-increment make the returned byte of one read coincide with the pointer step of the next. A soft reset issued right behind a data read makes the in-flight response coincide with the pointer and mode clear. A behavioural reference model with its own pointer, mode and byte store predicts every cycle's outputs, and the bench compares them on every clock. This judges both the returned byte and the address the following access uses.

// File: rtl/ibus_pkg.sv
package ibus_pkg;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_HI   = 2'd1,
    REG_LO   = 2'd2,
    REG_DATA = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    RSRC_ZERO = 2'd0,
    RSRC_MODE = 2'd1,
    RSRC_MEM  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic ldMode;
    logic softClr;
    logic ldHi;
    logic ldLo;
    logic step;
    logic memRd;
    logic memWr;
  } ctlStrb_t;

  localparam int MODE_RST_BIT = 7;
  localparam int MODE_INC_BIT = 1;
  localparam int MODE_IND_BIT = 0;
  localparam logic [7:0] MODE_LEGAL = 8'h83;

endpackage

// File: rtl/ibus_ctl.sv
module ibus_ctl
  import ibus_pkg::*;
#(
  parameter int HOST_AW  = 3,
  parameter int WIN_BASE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [7:0]         hostWdata,
  input  logic               autoInc,
  output ctlStrb_t           strb,
  output rdSrc_e             rdSrcQ,
  output logic               rvalidQ,
  output logic               modeErrQ
);

  localparam logic [HOST_AW-1:0] BASE_V = HOST_AW'(WIN_BASE);

  logic    winHit;
  regSel_e regSel;
  logic    modeLegal;
  logic    isRead;
  logic    modeBad;
  rdSrc_e  rdSrcNext;

  assign winHit    = hostSel && (hostAddr[HOST_AW-1:2] == BASE_V[HOST_AW-1:2]);
  assign regSel    = regSel_e'(hostAddr[1:0]);
  assign modeLegal = ((hostWdata & ~MODE_LEGAL) == 8'h00);
  assign isRead    = winHit && !hostWe;
  assign modeBad   = winHit && hostWe && (regSel == REG_MODE) && !modeLegal;

  always_comb begin
    strb      = '0;
    rdSrcNext = RSRC_ZERO;
    if (winHit) begin
      unique case (regSel)
        REG_MODE: begin
          if (hostWe && modeLegal) begin
            strb.softClr = hostWdata[MODE_RST_BIT];
            strb.ldMode  = !hostWdata[MODE_RST_BIT];
          end
          rdSrcNext = RSRC_MODE;
        end
        REG_HI: strb.ldHi = hostWe;
        REG_LO: strb.ldLo = hostWe;
        REG_DATA: begin
          strb.memWr = hostWe;
          strb.memRd = !hostWe;
          strb.step  = autoInc;
          rdSrcNext  = RSRC_MEM;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rvalidQ  <= 1'b0;
      modeErrQ <= 1'b0;
      rdSrcQ   <= RSRC_ZERO;
    end else begin
      rvalidQ  <= isRead;
      modeErrQ <= modeBad;
      rdSrcQ   <= isRead ? rdSrcNext : RSRC_ZERO;
    end
  end

endmodule

// File: rtl/ibus_dp.sv
module ibus_dp
  import ibus_pkg::*;
#(
  parameter int PTR_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  rdSrc_e           rdSrcQ,
  input  logic [7:0]       hostWdata,
  input  logic [7:0]       memRdata,
  output logic [PTR_W-1:0] ptrQ,
  output logic             autoInc,
  output logic [7:0]       rdData
);

  localparam int HI_W = PTR_W - 8;

  logic [1:0] modeQ;
  logic [7:0] modeByte;

  always_ff @(posedge clk) begin
    if (!rstN || strb.softClr) begin
      modeQ <= '0;
    end else if (strb.ldMode) begin
      modeQ <= {hostWdata[MODE_INC_BIT], hostWdata[MODE_IND_BIT]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.softClr) begin
      ptrQ <= '0;
    end else if (strb.ldHi) begin
      ptrQ[PTR_W-1:8] <= hostWdata[HI_W-1:0];
    end else if (strb.ldLo) begin
      ptrQ[7:0] <= hostWdata;
    end else if (strb.step) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  assign autoInc = modeQ[1];

  always_comb begin
    modeByte = 8'h00;
    modeByte[MODE_INC_BIT] = modeQ[1];
    modeByte[MODE_IND_BIT] = modeQ[0];
  end

  always_comb begin
    unique case (rdSrcQ)
      RSRC_MODE: rdData = modeByte;
      RSRC_MEM:  rdData = memRdata;
      default:   rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/ibus_host_port.sv
module ibus_host_port
  import ibus_pkg::*;
#(
  parameter int HOST_AW  = 3,
  parameter int WIN_BASE = 4,
  parameter int PTR_W    = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  output logic               hostRvalid,
  output logic               modeErr,
  output logic [PTR_W-1:0]   memAddr,
  output logic               memWe,
  output logic               memRe,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata
);

  ctlStrb_t strb;
  rdSrc_e   rdSrcQ;
  logic     autoInc;

  ibus_ctl #(.HOST_AW(HOST_AW), .WIN_BASE(WIN_BASE)) uCtl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .autoInc(autoInc),
    .strb(strb), .rdSrcQ(rdSrcQ), .rvalidQ(hostRvalid), .modeErrQ(modeErr)
  );

  ibus_dp #(.PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSrcQ(rdSrcQ),
    .hostWdata(hostWdata), .memRdata(memRdata), .ptrQ(memAddr),
    .autoInc(autoInc), .rdData(hostRdata)
  );

  assign memWe    = strb.memWr;
  assign memRe    = strb.memRd;
  assign memWdata = hostWdata;

endmodule

// File: rtl/ibus_host_port_chk.sv
module ibus_host_port_chk #(
  parameter int HOST_AW = 3,
  parameter int PTR_W   = 15
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostSel,
  input logic               hostWe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [7:0]         hostWdata,
  input logic               hostRvalid,
  input logic               modeErr,
  input logic [PTR_W-1:0]   memAddr,
  input logic               memWe,
  input logic               memRe,
  input logic               autoInc
);

  logic winRd;
  logic badMode;
  logic dataAcc;
  assign winRd   = hostSel && !hostWe && hostAddr[2];
  assign badMode = hostSel && hostWe && (hostAddr[2:0] == 3'd4) && ((hostWdata & 8'h7C) != 8'h00);
  assign dataAcc = memWe || memRe;

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rstN) winRd |=> hostRvalid); // R7
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rstN) hostRvalid |-> $past(winRd)); // R1
  AST_MEM_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN) $onehot0({memWe, memRe})); // R7
  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN) dataAcc |-> (hostSel && hostAddr[2])); // R1
  AST_MODE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN) modeErr |-> $past(badMode)); // R3
  AST_MODE_ERR_SEEN: assert property (@(posedge clk) disable iff (!rstN) badMode |=> modeErr); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && autoInc) |=> (memAddr == PTR_W'($past(memAddr) + 1'b1))); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !autoInc) |=> $stable(memAddr)); // R9

endmodule

bind ibus_host_port ibus_host_port_chk #(.HOST_AW(HOST_AW), .PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .hostRvalid(hostRvalid), .modeErr(modeErr),
  .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .autoInc(autoInc)
);

// File: tb/ibus_host_port_test.sv
module ibus_host_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSel = 1'b0;
  logic       hostWe = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       hostRvalid;
  logic       modeErr;
  logic [14:0] memAddr;
  logic       memWe;
  logic       memRe;
  logic [7:0] memWdata;
  logic [7:0] memRdata = 8'h00;

  int total = 0;
  int bad = 0;

  logic [7:0] ram [int];
  logic [7:0] refMem [int];
  int refPtr = 0;
  int refMode = 0;
  logic expRv = 1'b0;
  logic [7:0] expRd = 8'h00;
  logic expErr = 1'b0;
  string lastTag = "R1";

  always #10 clk = ~clk;

  ibus_host_port uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRvalid(hostRvalid),
    .modeErr(modeErr), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWe) ram[int'(memAddr)] = memWdata;
    if (memRe) memRdata <= ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 8'h00;
  end

  function automatic logic [7:0] refGet(int a);
    return refMem.exists(a) ? refMem[a] : 8'h00;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare outputs belonging to the previous cycle, then drive a new cycle.
  task automatic step(string tag, logic sel, logic we, logic [2:0] a, logic [7:0] d);
    logic expWe;
    logic expRe;
    check(lastTag, "hostRvalid", int'(hostRvalid), int'(expRv));
    if (expRv) check(lastTag, "hostRdata", int'(hostRdata), int'(expRd));
    check(lastTag, "modeErr", int'(modeErr), int'(expErr));
    expRv = 1'b0; expErr = 1'b0; expWe = 1'b0; expRe = 1'b0;
    if (sel && a[2]) begin
      case (a[1:0])
        2'd0: if (we) begin
                if ((d & 8'h7C) != 0) expErr = 1'b1;
                else if (d[7]) begin refMode = 0; refPtr = 0; end
                else refMode = int'(d & 8'h03);
              end else begin expRv = 1'b1; expRd = 8'(refMode); end
        2'd1: if (we) refPtr = ((int'(d) & 'h7F) << 8) | (refPtr & 'hFF);
              else begin expRv = 1'b1; expRd = 8'h00; end
        2'd2: if (we) refPtr = (refPtr & 'h7F00) | int'(d);
              else begin expRv = 1'b1; expRd = 8'h00; end
        default: begin
          if (we) begin refMem[refPtr] = d; expWe = 1'b1; end
          else begin expRv = 1'b1; expRd = refGet(refPtr); expRe = 1'b1; end
          if ((refMode & 2) != 0) refPtr = (refPtr + 1) & 'h7FFF;
        end
      endcase
    end
    hostSel = sel; hostWe = we; hostAddr = a; hostWdata = d;
    #1;
    check(tag, "memWe", int'(memWe), int'(expWe));
    check(tag, "memRe", int'(memRe), int'(expRe));
    lastTag = tag;
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R2", "reset hostRvalid", int'(hostRvalid), 0);
    check("R2", "reset memAddr", int'(memAddr), 0);
    step("R2", 1, 0, 3'd4, 8'h00);
    idle("R2");
    // R2 legal mode writes and readback
    step("R2", 1, 1, 3'd4, 8'h02);
    step("R2", 1, 0, 3'd4, 8'h00);
    step("R2", 1, 1, 3'd4, 8'h03);
    step("R2", 1, 0, 3'd4, 8'h00);
    // R3 illegal values refused
    step("R3", 1, 1, 3'd4, 8'h04);
    step("R3", 1, 0, 3'd4, 8'h00);
    step("R3", 1, 1, 3'd4, 8'hC3);
    step("R3", 1, 0, 3'd4, 8'h00);
    // R1 out-of-window cycles ignored
    step("R1", 1, 1, 3'd3, 8'h55);
    step("R1", 1, 0, 3'd3, 8'h00);
    step("R1", 1, 1, 3'd0, 8'h80);
    step("R1", 1, 0, 3'd1, 8'h00);
    step("R1", 1, 0, 3'd4, 8'h00);
    // R5 R6 R7 R8 streaming writes then back-to-back reads
    step("R5", 1, 1, 3'd5, 8'h12);
    step("R6", 1, 1, 3'd6, 8'h34);
    step("R7", 1, 1, 3'd7, 8'hAA);
    step("R8", 1, 1, 3'd7, 8'hBB);
    step("R8", 1, 1, 3'd7, 8'hCC);
    step("R6", 1, 1, 3'd6, 8'h34);
    step("R7", 1, 0, 3'd7, 8'h00);
    step("R8", 1, 0, 3'd7, 8'h00);
    step("R8", 1, 0, 3'd7, 8'h00);
    step("R8", 1, 0, 3'd7, 8'h00);
    // R5 keeps low byte, R6 keeps high byte
    step("R6", 1, 1, 3'd6, 8'h10);
    step("R5", 1, 1, 3'd5, 8'h01);
    step("R5", 1, 1, 3'd7, 8'h3C);
    step("R5", 1, 1, 3'd5, 8'h01);
    step("R5", 1, 1, 3'd6, 8'h10);
    step("R5", 1, 0, 3'd7, 8'h00);
    // R8 wrap from 0x7FFF; bit 7 of high write dropped
    step("R8", 1, 1, 3'd5, 8'hFF);
    step("R8", 1, 1, 3'd6, 8'hFF);
    step("R8", 1, 1, 3'd7, 8'h5A);
    step("R8", 1, 1, 3'd7, 8'h5B);
    step("R8", 1, 1, 3'd7, 8'h5C);
    step("R8", 1, 1, 3'd6, 8'h00);
    step("R8", 1, 1, 3'd5, 8'h00);
    step("R8", 1, 0, 3'd7, 8'h00);
    step("R8", 1, 0, 3'd7, 8'h00);
    step("R8", 1, 1, 3'd5, 8'h7F);
    step("R8", 1, 1, 3'd6, 8'hFF);
    step("R8", 1, 0, 3'd7, 8'h00);
    // R9 no increment
    step("R9", 1, 1, 3'd4, 8'h01);
    step("R9", 1, 1, 3'd6, 8'h40);
    step("R9", 1, 1, 3'd7, 8'h77);
    step("R9", 1, 1, 3'd7, 8'h78);
    step("R9", 1, 0, 3'd7, 8'h00);
    step("R9", 1, 0, 3'd7, 8'h00);
    // R10 address registers read as zero
    step("R10", 1, 0, 3'd5, 8'h00);
    step("R10", 1, 0, 3'd6, 8'h00);
    // R4 soft reset right behind a read in flight
    step("R4", 1, 1, 3'd4, 8'h03);
    step("R4", 1, 0, 3'd7, 8'h00);
    step("R4", 1, 1, 3'd4, 8'h83);
    step("R4", 1, 0, 3'd4, 8'h00);
    step("R4", 1, 0, 3'd7, 8'h00);
    step("R4", 1, 0, 3'd7, 8'h00);
    idle("R4");
    idle("R4");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule